// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the architectural state update that a 32-bit RISC core makes when it takes a synchronous exception. The pipeline presents a one-cycle request with a 4-bit cause code, the program counter of the faulting instruction and the program counter of the instruction after it. On the clock edge that accepts the request, the block does four things. It saves a return address and the old machine-state word into two save registers. It clears a fixed group of machine-state bits. It rewrites the syndrome register when the cause calls for it. It issues a one-cycle fetch-redirect strobe carrying the handler address.

Two causes are served: floating-point unit unavailable (code 7) and system call (code 8). The handler address is formed by concatenating the upper half of a vector-prefix register, bits 15:4 of the offset register indexed by the cause code, and four zero bits. No adder is involved. Code 9 (auxiliary unit unavailable) and every other code are never taken. A small write port loads the offset registers, the prefix register, the machine-state word and the syndrome register.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, save0, save1, mstate and syndrome read zero and redirect_valid is low.
- R2: A request with cause 7 loads save0 with cur_pc.
- R3: A request with cause 8 loads save0 with next_pc.
- R4: An accepted request loads save1 with the mstate value held before the accepting edge.
- R5: An accepted request clears mstate bits 26, 25, 18, 15, 14, 13, 11, 8, 5 and 4 (mask 0x0604E930, bit 0 = LSB). Every other bit keeps its value.
- R6: A cause-8 request sets syndrome to 0x00000020 when exc_short is 1 (short-encoding flag at bit 5), and to zero otherwise.
- R7: A cause-7 request leaves syndrome unchanged.
- R8: In the cycle after an accepted request, redirect_valid is high for exactly one cycle. redirect_addr then equals {prefix[31:16], offset[cause][15:4], 4'b0000}.
- R9: A request with any cause other than 7 or 8, including 9, changes no register and produces no redirect.
- R10: Write selects 0 to 15 load the offset register of that index, and select 16 loads the prefix register. A write in the same cycle as a request takes effect only after the handler address has been formed from the old value.
- R11: Select 17 loads mstate and select 18 loads syndrome, visible the next cycle. Such a write is dropped when it coincides with an accepted request.
- R12: Requests in consecutive cycles are each taken. The second one saves the mstate left by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_req | input | 1 | One-cycle exception request |
| exc_cause | input | 4 | Cause code of the request |
| exc_short | input | 1 | System-call instruction used the short encoding |
| cur_pc | input | 32 | Address of the excepting instruction |
| next_pc | input | 32 | Address of the following instruction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register write select |
| wr_data | input | 32 | Register write data |
| redirect_valid | output | 1 | Fetch-redirect strobe |
| redirect_addr | output | 32 | Handler fetch address |
| save0 | output | 32 | Saved return address |
| save1 | output | 32 | Saved machine-state word |
| mstate | output | 32 | Machine-state word |
| syndrome | output | 32 | Syndrome register |

## Verification
Several properties are checked on every accepted request: the choice of return address by cause, the copy of the old machine state into save1, the cleared and kept machine-state bits, a stable syndrome under cause 7, the single-cycle redirect strobe, the silence on unserved causes, and each offset-register write landing. Other behaviours need the bench's directed scenarios to show. These are the exact handler address built from programmed register values, the syndrome value under both system-call encodings, the ordering when a write collides with a request, the dropped machine-state and syndrome writes, and the chaining of two back-to-back requests.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN    = 32;
    localparam int OFF_CNT = 16;
    localparam int CAUSE_W = $clog2(OFF_CNT);
    localparam int SEL_W   = $clog2(OFF_CNT + 3);
    localparam int ALIGN   = 4;
    localparam int HALF    = XLEN / 2;
    localparam int MIDW    = HALF - ALIGN;

    localparam logic [CAUSE_W-1:0] CAUSE_FPU = CAUSE_W'(7);
    localparam logic [CAUSE_W-1:0] CAUSE_SYS = CAUSE_W'(8);
    localparam logic [CAUSE_W-1:0] CAUSE_AUX = CAUSE_W'(9);

    localparam logic [SEL_W-1:0] SEL_PFX = SEL_W'(OFF_CNT);
    localparam logic [SEL_W-1:0] SEL_MST = SEL_W'(OFF_CNT + 1);
    localparam logic [SEL_W-1:0] SEL_SYN = SEL_W'(OFF_CNT + 2);

    // machine-state bits forced low on entry (bit 0 = LSB)
    localparam int B_ULOCK  = 26;
    localparam int B_VEC    = 25;
    localparam int B_WAIT   = 18;
    localparam int B_EXTIRQ = 15;
    localparam int B_USER   = 14;
    localparam int B_FPU    = 13;
    localparam int B_FMODE0 = 11;
    localparam int B_FMODE1 = 8;
    localparam int B_IADDR  = 5;
    localparam int B_DADDR  = 4;

    localparam logic [XLEN-1:0] CLR_MASK =
        (XLEN'(1) << B_ULOCK)  | (XLEN'(1) << B_VEC)    |
        (XLEN'(1) << B_WAIT)   | (XLEN'(1) << B_EXTIRQ) |
        (XLEN'(1) << B_USER)   | (XLEN'(1) << B_FPU)    |
        (XLEN'(1) << B_FMODE0) | (XLEN'(1) << B_FMODE1) |
        (XLEN'(1) << B_IADDR)  | (XLEN'(1) << B_DADDR);

    localparam int SYN_SHORT_BIT = 5;

    typedef struct packed {
        logic [XLEN-1:0] save0;
        logic [XLEN-1:0] save1;
        logic [XLEN-1:0] mstate;
        logic [XLEN-1:0] synd;
        logic            redir_v;
        logic [XLEN-1:0] redir_addr;
    } core_state_t;

endpackage

// File: rtl/exc_offset_file.sv
module exc_offset_file
    import exc_entry_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int CNT   = OFF_CNT,
    parameter int SW    = SEL_W,
    parameter int IW    = CAUSE_W,
    parameter int HW    = W / 2,
    parameter int AL    = ALIGN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [HW-AL-1:0] off_field,
    output logic [HW-1:0]    pfx_field
);
    typedef struct packed {
        logic [CNT-1:0][W-1:0] off;
        logic [W-1:0]          pfx;
    } ofs_t;

    ofs_t            r_d, r_q;
    logic [CNT-1:0]  hit;
    logic            pfx_hit;

    for (genvar g = 0; g < CNT; g++) begin : g_entry
        assign hit[g] = wr_en && (wr_sel == SW'(g));

        assert_off_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> (r_q.off[g] == $past(wr_data)));
    end

    assign pfx_hit = wr_en && (wr_sel == SW'(CNT));

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < CNT; i++) begin
            if (hit[i]) r_d.off[i] = wr_data;
        end
        if (pfx_hit) r_d.pfx = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read uses the registered (old) contents
    assign off_field = r_q.off[rd_idx][HW-1:AL];
    assign pfx_field = r_q.pfx[W-1:HW];

endmodule

// File: rtl/exc_vec_build.sv
module exc_vec_build
    import exc_entry_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int HW = W / 2,
    parameter int AL = ALIGN
) (
    input  logic [HW-1:0]    pfx_field,
    input  logic [HW-AL-1:0] off_field,
    output logic [W-1:0]     handler_addr
);
    always_comb begin
        handler_addr = {pfx_field, off_field, AL'(0)};
    end
endmodule

// File: rtl/exc_state_core.sv
module exc_state_core
    import exc_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             is_sys,
    input  logic             short_enc,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  next_pc,
    input  logic [XLEN-1:0]  handler_addr,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  save0,
    output logic [XLEN-1:0]  save1,
    output logic [XLEN-1:0]  mstate,
    output logic [XLEN-1:0]  synd,
    output logic             redir_v,
    output logic [XLEN-1:0]  redir_addr
);
    core_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.redir_v = 1'b0;
        if (accept) begin
            st_d.save0      = is_sys ? next_pc : cur_pc;
            st_d.save1      = st_q.mstate;
            st_d.mstate     = st_q.mstate & ~CLR_MASK;
            if (is_sys) begin
                st_d.synd = short_enc ? (XLEN'(1) << SYN_SHORT_BIT) : '0;
            end
            st_d.redir_v    = 1'b1;
            st_d.redir_addr = handler_addr;
        end else if (wr_en) begin
            if (wr_sel == SEL_MST) st_d.mstate = wr_data;
            if (wr_sel == SEL_SYN) st_d.synd   = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign save0      = st_q.save0;
    assign save1      = st_q.save1;
    assign mstate     = st_q.mstate;
    assign synd       = st_q.synd;
    assign redir_v    = st_q.redir_v;
    assign redir_addr = st_q.redir_addr;

    assert_fpu_ret_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_sys) |=> (save0 == $past(cur_pc)));
    assert_sys_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_sys) |=> (save0 == $past(next_pc)));
    assert_save_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (save1 == $past(mstate)));
    assert_clear_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((mstate & CLR_MASK) == '0));
    assert_keep_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ((mstate & ~CLR_MASK) == ($past(mstate) & ~CLR_MASK)));
    assert_fpu_synd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_sys) |=> $stable(synd));
    assert_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redir_v |=> (!redir_v || $past(accept)));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               exc_short,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    next_pc,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [XLEN-1:0]    wr_data,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_addr,
    output logic [XLEN-1:0]    save0,
    output logic [XLEN-1:0]    save1,
    output logic [XLEN-1:0]    mstate,
    output logic [XLEN-1:0]    syndrome
);
    logic            served;
    logic            accept;
    logic            is_sys;
    logic [MIDW-1:0] off_field;
    logic [HALF-1:0] pfx_field;
    logic [XLEN-1:0] handler_addr;

    // cause 9 (auxiliary unit) and unknown codes are never taken
    always_comb begin
        served = (exc_cause == CAUSE_FPU) || (exc_cause == CAUSE_SYS);
        accept = exc_req && served;
        is_sys = (exc_cause == CAUSE_SYS);
    end

    exc_offset_file u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_idx    (exc_cause),
        .off_field (off_field),
        .pfx_field (pfx_field)
    );

    exc_vec_build u_vec (
        .pfx_field    (pfx_field),
        .off_field    (off_field),
        .handler_addr (handler_addr)
    );

    exc_state_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .is_sys       (is_sys),
        .short_enc    (exc_short),
        .cur_pc       (cur_pc),
        .next_pc      (next_pc),
        .handler_addr (handler_addr),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .save0        (save0),
        .save1        (save1),
        .mstate       (mstate),
        .synd         (syndrome),
        .redir_v      (redirect_valid),
        .redir_addr   (redirect_addr)
    );

    assert_ignore_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !served && !wr_en) |=>
            (!redirect_valid && $stable(save0) && $stable(save1) &&
             $stable(mstate) && $stable(syndrome)));
    assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> redirect_valid);

endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
    import exc_entry_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h0604_E930;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_req;
    logic [3:0]  exc_cause;
    logic        exc_short;
    logic [31:0] cur_pc, next_pc;
    logic        wr_en;
    logic [4:0]  wr_sel;
    logic [31:0] wr_data;
    logic        redirect_valid;
    logic [31:0] redirect_addr, save0, save1, mstate, syndrome;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_off [16];
    logic [31:0] m_pfx, m_ms, m_syn, m_s0, m_s1, m_addr;
    logic        m_rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_short(exc_short), .cur_pc(cur_pc), .next_pc(next_pc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .save0(save0), .save1(save1), .mstate(mstate), .syndrome(syndrome)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " save0"},    save0,    m_s0);
        chk({tag, " save1"},    save1,    m_s1);
        chk({tag, " mstate"},   mstate,   m_ms);
        chk({tag, " syndrome"}, syndrome, m_syn);
        chk({tag, " strobe"},   {31'd0, redirect_valid}, {31'd0, m_rv});
        if (m_rv) chk({tag, " addr"}, redirect_addr, m_addr);
    endtask

    // expected effect of taking a request, from the requirements
    task automatic model_take(int c, logic s, logic [31:0] cp, logic [31:0] np);
        m_rv = 1'b0;
        if (c == 7 || c == 8) begin
            m_addr = {m_pfx[31:16], m_off[c][15:4], 4'h0};
            m_s0   = (c == 8) ? np : cp;
            m_s1   = m_ms;
            m_ms   = m_ms & ~MASK;
            if (c == 8) m_syn = s ? 32'h20 : 32'h0;
            m_rv   = 1'b1;
        end
    endtask

    task automatic model_write(int sel, logic [31:0] d);
        if (sel < 16)       m_off[sel] = d;
        else if (sel == 16) m_pfx = d;
        else if (sel == 17) m_ms = d;
        else if (sel == 18) m_syn = d;
    endtask

    task automatic do_write(int sel, logic [31:0] d);
        wr_en = 1'b1; wr_sel = 5'(sel); wr_data = d;
        @(posedge clk); #1;
        model_write(sel, d);
        m_rv = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_exc(int c, logic s, logic [31:0] cp, logic [31:0] np, string tag);
        exc_req = 1'b1; exc_cause = 4'(c); exc_short = s; cur_pc = cp; next_pc = np;
        @(posedge clk); #1;
        model_take(c, s, cp, np);
        chk_all(tag);
        @(negedge clk);
        exc_req = 1'b0;
        #1;
        m_rv = 1'b0;
    endtask

    task automatic t_reset();
        m_pfx = '0; m_ms = '0; m_syn = '0; m_s0 = '0; m_s1 = '0; m_rv = 1'b0; m_addr = '0;
        for (int i = 0; i < 16; i++) m_off[i] = '0;
        chk_all("R1 reset");
    endtask

    task automatic t_fpu();
        do_write(16, 32'hABCD_1234);
        do_write(7,  32'h0000_5678);
        do_write(17, 32'hFFFF_FFFF);
        chk("R11 mstate write", mstate, 32'hFFFF_FFFF);
        do_write(18, 32'h0000_0080);
        do_exc(7, 1'b1, 32'h0000_1000, 32'h0000_1004, "R2 R4 R5 R7 R8 fpu");
        @(posedge clk); #1;
        chk("R8 strobe single cycle", {31'd0, redirect_valid}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_sys();
        do_write(8,  32'h0000_0ABF);
        do_write(17, MASK | 32'h0002_1202);
        do_write(18, 32'h0000_FFFF);
        do_exc(8, 1'b1, 32'h0000_2000, 32'h0000_2002, "R3 R5 R6 sys short");
        do_write(17, 32'hF0F0_F0F0);
        do_exc(8, 1'b0, 32'h0000_3000, 32'h0000_3004, "R3 R6 sys long");
    endtask

    task automatic t_ignore();
        do_exc(9, 1'b1, 32'h0000_4000, 32'h0000_4004, "R9 aux cause");
        do_exc(3, 1'b0, 32'h0000_5000, 32'h0000_5004, "R9 other cause");
    endtask

    task automatic t_collide();
        // offset write with request: old offset used, new one on next request
        wr_en = 1'b1; wr_sel = 5'd8; wr_data = 32'h0000_0550;
        do_exc(8, 1'b0, 32'h0000_6000, 32'h0000_6004, "R10 old offset");
        wr_en = 1'b0;
        model_write(8, 32'h0000_0550);
        do_exc(8, 1'b0, 32'h0000_6100, 32'h0000_6104, "R10 new offset");
        // machine-state and syndrome writes dropped during a request
        do_write(17, 32'hFFFF_0000);
        do_write(18, 32'h0000_00C0);
        wr_en = 1'b1; wr_sel = 5'd17; wr_data = 32'h1234_5678;
        do_exc(7, 1'b0, 32'h0000_7000, 32'h0000_7004, "R11 mstate write dropped");
        wr_sel = 5'd18; wr_data = 32'h0000_0001;
        do_exc(7, 1'b0, 32'h0000_7100, 32'h0000_7104, "R11 syndrome write dropped");
        wr_en = 1'b0;
    endtask

    task automatic t_b2b();
        do_write(17, 32'hFFFF_FFFF);
        exc_req = 1'b1; exc_cause = 4'd7; exc_short = 1'b0;
        cur_pc = 32'h0000_8000; next_pc = 32'h0000_8004;
        @(posedge clk); #1;
        model_take(7, 1'b0, 32'h0000_8000, 32'h0000_8004);
        chk_all("R12 first");
        @(negedge clk);
        exc_cause = 4'd8; exc_short = 1'b1;
        cur_pc = 32'h0000_9000; next_pc = 32'h0000_9002;
        @(posedge clk); #1;
        model_take(8, 1'b1, 32'h0000_9000, 32'h0000_9002);
        chk_all("R12 second");
        @(negedge clk);
        exc_req = 1'b0;
        #1;
        m_rv = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; exc_req = 1'b0; exc_cause = '0; exc_short = 1'b0;
        cur_pc = '0; next_pc = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_fpu();
        t_sys();
        t_ignore();
        t_collide();
        t_b2b();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule